// File: doc/BRIEF.md
# Swept-Frequency Numerically Controlled Oscillator

This block produces a digital sine wave whose frequency is set by a 10-bit frequency word. A 10-bit phase register adds the word on every clock. The sum wraps modulo 1024, so the phase is a sawtooth whose slope equals the word. The full phase addresses a registered 1024-entry table that holds one period of a sine in signed 11-bit form. The table is computed at elaboration, so it needs no memory image.

The word is not a static input. A built-in sequencer walks it through a fixed profile that climbs from 1 to 6 and then falls back to 2, which is ten steps in all. Each step lasts a dwell time given in clock cycles by a parameter, so the output frequency rises and then falls on its own. After the tenth step the word stays where it is.

Two controls act on the sequencer. An enable pauses the sweep. An override input replaces the sequenced word with an external one and freezes the sweep for as long as it is held. The phase register is never reloaded, so any change of word continues the phase smoothly from where it was.

Top module: `nco_sweep_top`

## Requirements
- R1: While `rst` is high at a clock edge, the phase becomes 0, the sine sample becomes 0, and the sweep returns to its first step, so `fcw_o` reads 1.
- R2: On every clock edge after reset, `phase_o` becomes (`phase_o` + `fcw_o`) mod 1024, using the values from before the edge.
- R3: `sine_o` is registered. After each edge it equals round(1023·sin(2π·p/1024)) as a signed two's-complement 11-bit value, where p is the `phase_o` value from before that edge.
- R4: With `sweep_en` high and `ovr_en` low, `fcw_o` steps through 1,2,3,4,5,6,5,4,3,2. Each step lasts exactly DWELL_CYC clock edges, counted from the release of reset.
- R5: Once the tenth step (word 2) is reached, `fcw_o` stays at 2 for as long as the sweep runs.
- R6: While `ovr_en` is high, `fcw_o` equals `ovr_word` and the accumulator uses it. The sweep position and the remaining dwell are frozen, and the sweep resumes from that point when `ovr_en` falls.
- R7: While `sweep_en` is low, the sweep position and the remaining dwell are frozen, while the phase keeps advancing by the current word.
- R8: At a change of step, the phase continues by the old word on the edge that changes the step, and by the new word from the next edge on. It is never reloaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sweep_en | input | 1 | Lets the sweep sequencer advance |
| ovr_en | input | 1 | Selects the external word and freezes the sweep |
| ovr_word | input | 10 | External frequency word |
| fcw_o | output | 10 | Frequency word applied in this cycle |
| phase_o | output | 10 | Phase register (sawtooth) |
| sine_o | output | 11 | Signed sine sample of the previous cycle's phase |

## Verification
The word on `fcw_o` is combinational from the sweep state and the override inputs, so it is due in the same cycle as a change of input. It changes one edge after the dwell counter expires. `phase_o` reflects a word one edge after that word appears, and `sine_o` reflects a phase one further edge later. The bench drives inputs on the falling edge. On each rising edge it advances a cycle model built from these latencies, and it compares all three outputs at the next falling edge. It also checks the step boundaries, the wrap and the frozen sweep position at the exact cycle counts that the dwell parameter implies.

// File: rtl/nco_sweep_pkg.sv
package nco_sweep_pkg;

  // Rounded sine code for table index idx out of depth entries, scaled to peak.
  function automatic int sine_code(int idx, int depth, int peak);
    real ang;
    real v;
    ang = 2.0 * 3.14159265358979 * real'(idx) / real'(depth);
    v   = $sin(ang) * real'(peak);
    if (v >= 0.0) return $rtoi(v + 0.5);
    else          return -$rtoi(-v + 0.5);
  endfunction

  // Frequency word for a sweep step: climb for rise steps, then descend.
  function automatic int sweep_word(int step, int rise, int start);
    if (step <= rise) return start + step;
    else              return start + 2 * rise - step;
  endfunction

  // Modular phase addition for a w-bit register.
  function automatic int wrap_add(int a, int b, int w);
    return (a + b) % (1 << w);
  endfunction

endpackage

// File: rtl/nco_sweep_seq.sv
module nco_sweep_seq
  import nco_sweep_pkg::*;
#(
  parameter int FCW_W      = 10,
  parameter int NUM_STEPS  = 10,
  parameter int RISE_STEPS = 5,
  parameter int START_WORD = 1,
  parameter int DWELL_CYC  = 2000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  output logic [FCW_W-1:0] word_o,
  output logic             step_adv_o,
  output logic             at_last_o
);
  localparam int STEP_W = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1;
  localparam int CNT_W  = $clog2(DWELL_CYC + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);
  localparam logic [CNT_W-1:0]  CNT_LOAD  = CNT_W'(DWELL_CYC - 1);

  logic [STEP_W-1:0] step_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              cnt_zero;

  assign at_last_o  = (step_q == LAST_STEP);
  assign cnt_zero   = (cnt_q == '0);
  assign step_adv_o = run && !at_last_o && cnt_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
      cnt_q  <= CNT_LOAD;
    end else if (run && !at_last_o) begin
      if (cnt_zero) begin
        step_q <= step_q + 1'b1;
        cnt_q  <= CNT_LOAD;
      end else begin
        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign word_o = FCW_W'(sweep_word(int'(step_q), RISE_STEPS, START_WORD));

  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
    step_q <= LAST_STEP); // R4

  AST_STEP_INC: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && step_q != $past(step_q)) |-> (step_q == $past(step_q) + 1'b1 && $past(run))); // R4

  AST_LAST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(at_last_o)) |-> at_last_o); // R5

  AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(run)) |-> ($stable(step_q) && $stable(cnt_q))); // R6

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int FCW_W   = 10,
  parameter int PHASE_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FCW_W-1:0]   inc,
  output logic [PHASE_W-1:0] phase_o
);
  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] inc_ext;

  generate
    if (FCW_W >= PHASE_W) begin : g_trunc
      assign inc_ext = inc[PHASE_W-1:0];
    end else begin : g_ext
      assign inc_ext = {{(PHASE_W-FCW_W){1'b0}}, inc};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= phase_q + inc_ext;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/nco_sine_rom.sv
module nco_sine_rom
  import nco_sweep_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 11
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr,
  output logic signed [DATA_W-1:0] data_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PEAK  = (1 << (DATA_W - 1)) - 1;

  logic signed [DATA_W-1:0] tab [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_tab
      localparam int VAL = sine_code(g, DEPTH, PEAK);
      assign tab[g] = DATA_W'(VAL);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) data_o <= '0;
    else     data_o <= tab[addr];
  end
endmodule

// File: rtl/nco_sweep_top.sv
module nco_sweep_top
  import nco_sweep_pkg::*;
#(
  parameter int FCW_W      = 10,
  parameter int PHASE_W    = 10,
  parameter int AMP_W      = 11,
  parameter int NUM_STEPS  = 10,
  parameter int RISE_STEPS = 5,
  parameter int START_WORD = 1,
  parameter int DWELL_CYC  = 2000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sweep_en,
  input  logic                    ovr_en,
  input  logic [FCW_W-1:0]        ovr_word,
  output logic [FCW_W-1:0]        fcw_o,
  output logic [PHASE_W-1:0]      phase_o,
  output logic signed [AMP_W-1:0] sine_o
);
  localparam int PEAK = (1 << (AMP_W - 1)) - 1;

  logic             seq_run;
  logic [FCW_W-1:0] seq_word;
  logic             step_adv;
  logic             at_last;

  assign seq_run = sweep_en && !ovr_en;

  nco_sweep_seq #(
    .FCW_W(FCW_W), .NUM_STEPS(NUM_STEPS), .RISE_STEPS(RISE_STEPS),
    .START_WORD(START_WORD), .DWELL_CYC(DWELL_CYC)
  ) seq_i (
    .clk(clk), .rst(rst), .run(seq_run),
    .word_o(seq_word), .step_adv_o(step_adv), .at_last_o(at_last)
  );

  assign fcw_o = ovr_en ? ovr_word : seq_word;

  nco_phase_acc #(.FCW_W(FCW_W), .PHASE_W(PHASE_W)) acc_i (
    .clk(clk), .rst(rst), .inc(fcw_o), .phase_o(phase_o)
  );

  nco_sine_rom #(.ADDR_W(PHASE_W), .DATA_W(AMP_W)) rom_i (
    .clk(clk), .rst(rst), .addr(phase_o), .data_o(sine_o)
  );

  AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (int'(phase_o) == wrap_add(int'($past(phase_o)), int'($past(fcw_o)), PHASE_W))); // R2

  AST_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(step_adv)) |-> (int'(phase_o) == wrap_add(int'($past(phase_o)), int'($past(seq_word)), PHASE_W))); // R8

  AST_SINE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (int'(sine_o) == sine_code(int'($past(phase_o)), 1 << PHASE_W, PEAK))); // R3

  AST_OVR_WORD: assert property (@(posedge clk) disable iff (rst)
    ovr_en |-> (fcw_o == ovr_word)); // R6

  AST_OVR_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ovr_en)) |-> $stable(seq_word)); // R6

  AST_LAST_WORD: assert property (@(posedge clk) disable iff (rst)
    at_last |-> (int'(seq_word) == sweep_word(NUM_STEPS - 1, RISE_STEPS, START_WORD))); // R5

endmodule

// File: tb/nco_sweep_top_tb_top.sv
`timescale 1ns/1ps
module nco_sweep_top_tb_top;
  localparam int DWELL = 16;
  localparam int WATCHDOG_NS = 400000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sweep_en = 1'b0;
  logic              ovr_en = 1'b0;
  logic [9:0]        ovr_word = '0;
  logic [9:0]        fcw_o;
  logic [9:0]        phase_o;
  logic signed [10:0] sine_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Bench-side model of the block
  int m_phase = 0;
  int m_step = 0;
  int m_elapsed = 0;
  int m_sine = 0;

  int profile [10] = '{1, 2, 3, 4, 5, 6, 5, 4, 3, 2};

  always #2.5 clk = ~clk;

  nco_sweep_top #(.DWELL_CYC(DWELL)) dut_i (
    .clk(clk), .rst(rst), .sweep_en(sweep_en), .ovr_en(ovr_en),
    .ovr_word(ovr_word), .fcw_o(fcw_o), .phase_o(phase_o), .sine_o(sine_o)
  );

  function automatic int ref_sine(int p);
    real a;
    real v;
    a = 2.0 * 3.14159265358979 * real'(p) / 1024.0;
    v = $sin(a) * 1023.0;
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  function automatic int exp_word();
    if (ovr_en) return int'(ovr_word);
    return profile[m_step];
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: advance model at the rising edge, compare at the falling edge.
  task automatic cyc(string word_req);
    int eff;
    @(posedge clk);
    if (rst) begin
      m_phase = 0; m_step = 0; m_elapsed = 0; m_sine = 0;
    end else begin
      eff = exp_word();
      m_sine  = ref_sine(m_phase);
      m_phase = (m_phase + eff) % 1024;
      if (sweep_en && !ovr_en && m_step < 9) begin
        m_elapsed++;
        if (m_elapsed == DWELL) begin
          m_step++;
          m_elapsed = 0;
        end
      end
    end
    @(negedge clk);
    check(int'(fcw_o) == exp_word(), word_req, int'(fcw_o), exp_word());
    check(int'(phase_o) == m_phase, "R2", int'(phase_o), m_phase);
    check(int'(sine_o) == m_sine, "R3", int'(sine_o), m_sine);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1; sweep_en = 1'b0; ovr_en = 1'b0;
    for (int i = 0; i < 3; i++) cyc("R1");
    rst = 1'b0;
  endtask

  task automatic t_reset();
    apply_reset();
    check(fcw_o == 10'd1, "R1", int'(fcw_o), 1);
    check(phase_o == 10'd0, "R1", int'(phase_o), 0);
    check(sine_o == 11'sd0, "R1", int'(sine_o), 0);
  endtask

  task automatic t_sweep();
    int prev_phase;
    int prev_word;
    apply_reset();
    sweep_en = 1'b1;
    for (int k = 0; k < 10; k++) begin
      for (int c = 0; c < DWELL; c++) begin
        prev_phase = int'(phase_o);
        prev_word  = int'(fcw_o);
        // word of step k is held from edge k*DWELL up to edge (k+1)*DWELL
        check(int'(fcw_o) == profile[k], "R4", int'(fcw_o), profile[k]);
        cyc("R4");
        if (c == DWELL - 1 && k < 9) begin
          // R8: boundary edge advanced by the old word
          check(int'(phase_o) == (prev_phase + prev_word) % 1024, "R8",
                int'(phase_o), (prev_phase + prev_word) % 1024);
        end
        if (c == 0 && k > 0) begin
          check(int'(phase_o) == (prev_phase + profile[k]) % 1024, "R8",
                int'(phase_o), (prev_phase + profile[k]) % 1024);
        end
      end
    end
    for (int i = 0; i < 3 * DWELL; i++) cyc("R5");
    check(fcw_o == 10'd2, "R5", int'(fcw_o), 2);
  endtask

  task automatic t_wrap();
    int p0;
    apply_reset();
    ovr_en = 1'b1; ovr_word = 10'd700;
    p0 = int'(phase_o);
    cyc("R6");
    check(int'(phase_o) == (p0 + 700) % 1024, "R2", int'(phase_o), (p0 + 700) % 1024);
    cyc("R6");
    check(int'(phase_o) == 376, "R2", int'(phase_o), 376);
    ovr_word = 10'd1023;
    cyc("R6");
    check(int'(phase_o) == 375, "R2", int'(phase_o), 375);
    ovr_en = 1'b0;
  endtask

  task automatic t_override();
    apply_reset();
    sweep_en = 1'b1;
    for (int i = 0; i < 3 * DWELL + 5; i++) cyc("R4");
    check(fcw_o == 10'd4, "R6", int'(fcw_o), 4);
    ovr_en = 1'b1; ovr_word = 10'd37;
    for (int i = 0; i < 5 * DWELL; i++) cyc("R6");
    check(fcw_o == 10'd37, "R6", int'(fcw_o), 37);
    ovr_en = 1'b0;
    #0;
    check(fcw_o == 10'd4, "R6", int'(fcw_o), 4);
    // remaining dwell of step 3 was DWELL-5 edges
    for (int i = 0; i < DWELL - 6; i++) cyc("R6");
    check(fcw_o == 10'd4, "R6", int'(fcw_o), 4);
    cyc("R6");
    check(fcw_o == 10'd5, "R6", int'(fcw_o), 5);
  endtask

  task automatic t_pause();
    int p0;
    apply_reset();
    sweep_en = 1'b1;
    for (int i = 0; i < DWELL + 3; i++) cyc("R4");
    sweep_en = 1'b0;
    p0 = int'(phase_o);
    for (int i = 0; i < 4 * DWELL; i++) cyc("R7");
    check(fcw_o == 10'd2, "R7", int'(fcw_o), 2);
    check(int'(phase_o) == (p0 + 2 * 4 * DWELL) % 1024, "R7",
          int'(phase_o), (p0 + 2 * 4 * DWELL) % 1024);
    sweep_en = 1'b1;
    for (int i = 0; i < DWELL - 4; i++) cyc("R7");
    check(fcw_o == 10'd2, "R7", int'(fcw_o), 2);
    cyc("R7");
    check(fcw_o == 10'd3, "R7", int'(fcw_o), 3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(WATCHDOG_NS);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_sweep();
    t_wrap();
    t_override();
    t_pause();
    finish_run();
  end
endmodule